// File: doc/BRIEF.md
# SPI Master Serial Transceiver

This block is a byte-wide serial port that acts as the controller on an SPI link. Software hands it one character at a time through a single-entry holding register. When the shift stage is free, the character moves from the holding register into a shift register. It is then sent MSB first while the byte coming back from the slave is collected at the same time. Each completed received byte lands in a single-entry receive register, which the host reads with a strobe.

The serial clock comes from a programmable bit-time counter: one bit time equals `bit_div` system clocks. The block frames every character with the active-low slave select. Select goes low one bit time before the first data bit, stays low one bit time after the last, and is then released for at least one bit time. For slaves that need select held across several characters, a command pins the select line low until a matching release command.

An optional gating mode holds back the next transmission until the host has read the previous received byte, so that no received data is overwritten. Ready, empty and overrun flags report the state of both directions.

Top module: `spi_mst_xcvr`

## Requirements
- R1: A `wr_thr` pulse while `tx_rdy` is high stores `wr_data` and drops `tx_rdy` in the next cycle. Once the shift stage is idle and the start conditions hold, the byte moves to the shifter and `tx_rdy` is high again one cycle later.
- R2: `tx_empty` is high only while the transmitter is enabled, no byte is queued and the shifter has finished the whole frame, including the release gap. Whenever `tx_empty` is high, `tx_rdy` is high too.
- R3: With `tx_en` low, `tx_rdy` and `tx_empty` both read 0 and no new frame starts. A write made while disabled is lost.
- R4: A `wr_thr` pulse while `tx_rdy` is low has no effect. The queued byte keeps its value, and the lost byte is never sent.
- R5: With `wait_rd` = 0, frames start whatever the state of `rx_rdy`. With `wait_rd` = 1, a frame starts only while `rx_rdy` is 0.
- R6: When select is not forced, `ss_n` falls as a frame starts and stays low for exactly 10 bit times: one setup bit time, 8 data bit times and one hold bit time. Between frames it is high for at least one bit time, so at least three bit times separate the data bits of consecutive characters.
- R7: Each data bit time begins with `sclk` low for `bit_div - bit_div/2` clocks, followed by `sclk` high for `bit_div/2` clocks. `sclk` idles low. `mosi` carries the character MSB first and changes only on falling `sclk`; `miso` is sampled on rising `sclk`. The first rising `sclk` comes `2*bit_div - bit_div/2` clocks after `ss_n` falls. `bit_div` must be at least 2 and stay constant during a frame.
- R8: At the end of each frame, the received byte goes to `rx_data` and `rx_rdy` rises. If `rx_rdy` is still set and not being read in that cycle, `rx_ovr` is set and the new byte replaces the old one.
- R9: `rx_ovr` stays set until a `cmd_clr_status` pulse clears it. Reading the receive register does not clear it.
- R10: A `cmd_force_sel` pulse drives `ss_n` low from the next cycle and keeps it low across frames. Only `cmd_release_sel` returns it to automatic framing; if both pulses arrive in the same cycle, the release wins.
- R11: An `rd_rhr` pulse clears `rx_rdy` from the next cycle. If a read and a new byte arrive in the same cycle, the new byte counts as fresh: `rx_rdy` stays 1 and `rx_ovr` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| wait_rd | input | 1 | Gate each start on the receive register having been read |
| bit_div | input | DIV_W | System clocks per bit time (at least 2) |
| wr_thr | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | CHAR_W | Character to queue |
| rd_rhr | input | 1 | Read strobe for the receive register |
| cmd_force_sel | input | 1 | Command: hold slave select low |
| cmd_release_sel | input | 1 | Command: return slave select to automatic framing |
| cmd_clr_status | input | 1 | Command: clear the overrun flag |
| miso | input | 1 | Serial data from the slave |
| tx_rdy | output | 1 | Holding register can accept a character |
| tx_empty | output | 1 | Every written character has been fully sent |
| rx_rdy | output | 1 | Receive register holds an unread byte |
| rx_ovr | output | 1 | A byte arrived while the previous one was unread |
| rx_data | output | CHAR_W | Receive register contents |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |

## Verification
A bit-time counter that drifts would show up within a single character. The length of the `ss_n` low window, the offset of the first `sclk` rise and the `sclk` high width would all differ from the values computed from `bit_div`. A shift or bit-index fault shows up as a wrong byte on `mosi`, or as a wrong `rx_data` for a frame, at the end of that same frame. Faults in the holding-register flags, the gating mode or the overrun logic show up within a cycle or two of the write, read or arrival that exercises them: a stale `tx_rdy`, a frame that starts while it should be held back, or an overrun flag that is missing or sticks.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;
  // Frame phases of the shift sequencer, one bit time each except SHIFT
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_SHIFT = 3'd2,
    PH_HOLD  = 3'd3,
    PH_GAP   = 3'd4
  } phase_e;
endpackage

// File: rtl/spi_mst_bittmr.sv
module spi_mst_bittmr #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             rise_tick,
  output logic             end_tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lo_len;

  // Low part of a bit time is the larger half
  assign lo_len    = div - (div >> 1);
  assign end_tick  = run && (cnt >= div - 1'b1);
  assign rise_tick = run && (cnt == lo_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (end_tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && run && $stable(div) && div >= 2) |-> (cnt < div));
endmodule

// File: rtl/spi_mst_shifter.sv
module spi_mst_shifter
  import spi_mst_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CHAR_W-1:0] tx_byte,
  input  logic [DIV_W-1:0]  div,
  input  logic              miso,
  output logic              busy,
  output logic              sel_auto,
  output logic              sclk,
  output logic              mosi,
  output logic              rx_done,
  output logic [CHAR_W-1:0] rx_byte
);
  localparam int IDX_W = $clog2(CHAR_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHAR_W - 1);

  phase_e            ph;
  logic [CHAR_W-1:0] sh;
  logic [IDX_W-1:0]  bit_idx;
  logic              sclk_q, mosi_q, sel_q, done_q;
  logic              run, rise_tick, end_tick;

  assign run = (ph != PH_IDLE);

  spi_mst_bittmr #(.DIV_W(DIV_W)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .div       (div),
    .rise_tick (rise_tick),
    .end_tick  (end_tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      sh      <= '0;
      bit_idx <= '0;
      sclk_q  <= 1'b0;
      mosi_q  <= 1'b0;
      sel_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (ph)
        PH_IDLE: begin
          if (start) begin
            ph      <= PH_SETUP;
            sh      <= tx_byte;
            mosi_q  <= tx_byte[CHAR_W-1];
            sel_q   <= 1'b1;
            bit_idx <= '0;
          end
        end
        PH_SETUP: begin
          if (end_tick) ph <= PH_SHIFT;
        end
        PH_SHIFT: begin
          if (rise_tick) begin
            sclk_q <= 1'b1;
            sh     <= {sh[CHAR_W-2:0], miso};
          end
          if (end_tick) begin
            sclk_q <= 1'b0;
            if (bit_idx == LAST_IDX) begin
              ph     <= PH_HOLD;
              done_q <= 1'b1;
              mosi_q <= 1'b0;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              mosi_q  <= sh[CHAR_W-1];
            end
          end
        end
        PH_HOLD: begin
          if (end_tick) begin
            ph    <= PH_GAP;
            sel_q <= 1'b0;
          end
        end
        PH_GAP: begin
          if (end_tick) ph <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign busy     = run;
  assign sel_auto = sel_q;
  assign sclk     = sclk_q;
  assign mosi     = mosi_q;
  assign rx_done  = done_q;
  assign rx_byte  = sh;

  // Serial clock only toggles inside the data phase
  p_sclk_in_shift_r7: assert property (@(posedge clk) disable iff (rst)
    sclk_q |-> (ph == PH_SHIFT));
  // mosi only moves on a falling sclk, a frame load, or the frame end
  p_mosi_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(ph) == PH_SHIFT && ph == PH_SHIFT && !$stable(mosi_q)) |-> $fell(sclk_q));
endmodule

// File: rtl/spi_mst_rxbuf.sv
module spi_mst_rxbuf #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [CHAR_W-1:0] byte_in,
  input  logic              rd,
  input  logic              clr_sta,
  output logic [CHAR_W-1:0] rhr,
  output logic              rdy,
  output logic              ovr
);
  logic [CHAR_W-1:0] rhr_q;
  logic              rdy_q, ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rhr_q <= '0;
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (done) begin
        rhr_q <= byte_in;
        rdy_q <= 1'b1;
      end else if (rd) begin
        rdy_q <= 1'b0;
      end
      if (done && rdy_q && !rd) ovr_q <= 1'b1;
      else if (clr_sta) ovr_q <= 1'b0;
    end
  end

  assign rhr = rhr_q;
  assign rdy = rdy_q;
  assign ovr = ovr_q;

  p_rdy_on_arrival_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> rdy_q);
  p_ovr_set_r8: assert property (@(posedge clk) disable iff (rst)
    (done && rdy_q && !rd) |=> ovr_q);
  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !clr_sta) |=> ovr_q);
  p_fresh_on_read_r11: assert property (@(posedge clk) disable iff (rst)
    (done && rd && !ovr_q) |=> (rdy_q && !ovr_q));
  p_read_clears_r11: assert property (@(posedge clk) disable iff (rst)
    (rd && !done) |=> !rdy_q);
endmodule

// File: rtl/spi_mst_xcvr.sv
module spi_mst_xcvr
  import spi_mst_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              wait_rd,
  input  logic [DIV_W-1:0]  bit_div,
  input  logic              wr_thr,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              rd_rhr,
  input  logic              cmd_force_sel,
  input  logic              cmd_release_sel,
  input  logic              cmd_clr_status,
  input  logic              miso,
  output logic              tx_rdy,
  output logic              tx_empty,
  output logic              rx_rdy,
  output logic              rx_ovr,
  output logic [CHAR_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  output logic              ss_n
);
  logic [CHAR_W-1:0] thr_q;
  logic              thr_full;
  logic              force_q;
  logic              busy, sel_auto, start;
  logic              rx_done;
  logic [CHAR_W-1:0] rx_byte;

  // A queued byte may start when the shifter is free and gating allows
  assign start    = !busy && thr_full && tx_en && !(wait_rd && rx_rdy);
  assign tx_rdy   = tx_en && !thr_full;
  assign tx_empty = tx_en && !thr_full && !busy;
  assign ss_n     = !(force_q || sel_auto);

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q    <= '0;
      thr_full <= 1'b0;
    end else if (start) begin
      thr_full <= 1'b0;
    end else if (wr_thr && tx_rdy) begin
      thr_q    <= wr_data;
      thr_full <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) force_q <= 1'b0;
    else if (cmd_release_sel) force_q <= 1'b0;
    else if (cmd_force_sel) force_q <= 1'b1;
  end

  spi_mst_shifter #(.CHAR_W(CHAR_W), .DIV_W(DIV_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .tx_byte  (thr_q),
    .div      (bit_div),
    .miso     (miso),
    .busy     (busy),
    .sel_auto (sel_auto),
    .sclk     (sclk),
    .mosi     (mosi),
    .rx_done  (rx_done),
    .rx_byte  (rx_byte)
  );

  spi_mst_rxbuf #(.CHAR_W(CHAR_W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .done    (rx_done),
    .byte_in (rx_byte),
    .rd      (rd_rhr),
    .clr_sta (cmd_clr_status),
    .rhr     (rx_data),
    .rdy     (rx_rdy),
    .ovr     (rx_ovr)
  );

  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_thr && tx_rdy) |=> !tx_rdy);
  p_empty_has_room_r2: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> tx_rdy);
  p_lost_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_thr && !tx_rdy) |=> $stable(thr_q));
  p_gate_on_read_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && $past(wait_rd)) |-> !$past(rx_rdy));
  p_sclk_inside_sel_r6: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !ss_n);
  p_force_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (force_q && !cmd_release_sel) |=> !ss_n);
endmodule

// File: tb/spi_mst_xcvr_tb.sv
`timescale 1ns/1ps
module spi_mst_xcvr_tb;
  localparam int CW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, wait_rd = 1'b0;
  logic [DW-1:0] bit_div = 8'd2;
  logic wr_thr = 1'b0, rd_rhr = 1'b0;
  logic [CW-1:0] wr_data = '0;
  logic cmd_force_sel = 1'b0, cmd_release_sel = 1'b0, cmd_clr_status = 1'b0;
  logic miso;
  logic tx_rdy, tx_empty, rx_rdy, rx_ovr, sclk, mosi, ss_n;
  logic [CW-1:0] rx_data;

  always #4 clk = ~clk;

  spi_mst_xcvr #(.CHAR_W(CW), .DIV_W(DW)) u_dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .wait_rd(wait_rd), .bit_div(bit_div),
    .wr_thr(wr_thr), .wr_data(wr_data), .rd_rhr(rd_rhr),
    .cmd_force_sel(cmd_force_sel), .cmd_release_sel(cmd_release_sel),
    .cmd_clr_status(cmd_clr_status), .miso(miso),
    .tx_rdy(tx_rdy), .tx_empty(tx_empty), .rx_rdy(rx_rdy), .rx_ovr(rx_ovr),
    .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .ss_n(ss_n)
  );

  int nchk = 0, nfail = 0;
  bit done_flag = 0;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input int act, input int lim);
    nchk++;
    if (act < lim) begin
      nfail++;
      $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
    end
  endtask

  // Slave model: byte n returned by the slave is computed from n
  function automatic logic [7:0] slv_byte(input int n);
    return 8'hA5 ^ 8'(n * 37);
  endfunction

  // Monitor, sampled away from the active edge
  int cyc = 0, t_fall = 0, t_ssrise = 0, last_len = 0, last_gap = 0;
  int first_off = 0, nss = 0, hi_run = 0, last_hi = 0;
  int mbits = 0, nbytes = 0;
  bit saw_rise = 0, p_ss = 1, p_sclk = 0;
  logic [7:0] mbyte = '0, mos_last = '0;

  assign miso = slv_byte(nbytes)[7 - mbits];

  always @(negedge clk) begin
    cyc++;
    if (p_ss && !ss_n) begin
      if (nss > 0) last_gap = cyc - t_ssrise;
      t_fall = cyc; saw_rise = 0;
    end
    if (!p_ss && ss_n) begin
      last_len = cyc - t_fall; nss++; t_ssrise = cyc;
    end
    if (!p_sclk && sclk) begin
      if (!saw_rise) begin first_off = cyc - t_fall; saw_rise = 1; end
      mbyte = {mbyte[6:0], mosi};
      mbits++;
      if (mbits == 8) begin mos_last = mbyte; nbytes++; mbits = 0; end
    end
    if (sclk) hi_run++;
    if (p_sclk && !sclk) begin last_hi = hi_run; hi_run = 0; end
    p_ss = ss_n; p_sclk = sclk;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    for (int i = 0; i < 4000 && !tx_rdy; i++) @(negedge clk);
    wr_data = b; wr_thr = 1'b1;
    @(negedge clk);
    wr_thr = 1'b0;
  endtask

  task automatic wait_empty(input string req);
    for (int i = 0; i < 4000 && !tx_empty; i++) @(negedge clk);
    chk(req, int'(tx_empty), 1);
  endtask

  task automatic pulse_rd();
    rd_rhr = 1'b1; @(negedge clk); rd_rhr = 1'b0;
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    int n0, s0;
    logic [7:0] b;
    tick(3); rst = 1'b0; tick(1);
    // Reset state, transmitter disabled (R3)
    chk("R3 reset tx_rdy", int'(tx_rdy), 0);
    chk("R3 reset tx_empty", int'(tx_empty), 0);
    chk("R6 reset ss_n", int'(ss_n), 1);
    chk("R7 reset sclk", int'(sclk), 0);
    chk("R8 reset rx_rdy", int'(rx_rdy), 0);
    chk("R9 reset rx_ovr", int'(rx_ovr), 0);
    tx_en = 1'b1; tick(1);
    chk("R2 idle tx_empty", int'(tx_empty), 1);
    chk("R1 idle tx_rdy", int'(tx_rdy), 1);

    // Sweep bit time and data patterns (R6 R7 R8 R11)
    for (int d = 2; d <= 5; d++) begin
      bit_div = 8'(d);
      for (int k = 0; k < 4; k++) begin
        b = 8'h81 ^ 8'(k * 90) ^ 8'(d);
        send(b);
        wait_empty("R2 frame end");
        chk("R7 mosi byte", int'(mos_last), int'(b));
        chk("R6 ss low length", last_len, 10 * d);
        chk("R7 first rise offset", first_off, 2 * d - d / 2);
        chk("R7 sclk high width", last_hi, d / 2);
        chk("R8 rx_data", int'(rx_data), int'(slv_byte(nbytes - 1)));
        chk("R8 rx_rdy set", int'(rx_rdy), 1);
        chk("R8 no overrun", int'(rx_ovr), 0);
        pulse_rd();
        chk("R11 read clears", int'(rx_rdy), 0);
      end
    end

    // Back to back, lost write, overrun (R1 R2 R4 R6 R8 R9)
    bit_div = 8'd3;
    n0 = nbytes;
    send(8'h3C);
    chk("R1 tx_rdy low after write", int'(tx_rdy), 0);
    tick(1);
    chk("R1 tx_rdy back after load", int'(tx_rdy), 1);
    chk("R2 not empty while shifting", int'(tx_empty), 0);
    send(8'hC6);
    chk("R4 tx_rdy low when queued", int'(tx_rdy), 0);
    wr_data = 8'h77; wr_thr = 1'b1; @(negedge clk); wr_thr = 1'b0;
    wait_empty("R2 after pair");
    chk("R4 lost write not sent", nbytes - n0, 2);
    chk("R4 queued byte intact", int'(mos_last), 8'hC6);
    chk_ge("R6 ss high gap", last_gap, 3);
    chk("R8 overrun set", int'(rx_ovr), 1);
    chk("R8 newest byte kept", int'(rx_data), int'(slv_byte(nbytes - 1)));
    tick(20);
    chk("R9 overrun sticky", int'(rx_ovr), 1);
    pulse_rd();
    chk("R9 read keeps overrun", int'(rx_ovr), 1);
    cmd_clr_status = 1'b1; @(negedge clk); cmd_clr_status = 1'b0;
    chk("R9 clear command", int'(rx_ovr), 0);

    // Wait-for-read gating (R5)
    wait_rd = 1'b1;
    send(8'h5A); wait_empty("R5 first");
    n0 = nbytes;
    send(8'hE1);
    tick(90);
    chk("R5 held while unread", nbytes - n0, 0);
    chk("R5 tx_rdy stays low", int'(tx_rdy), 0);
    pulse_rd();
    wait_empty("R5 released");
    chk("R5 sent after read", nbytes - n0, 1);
    chk("R5 byte after read", int'(mos_last), 8'hE1);
    chk("R5 no overrun", int'(rx_ovr), 0);
    wait_rd = 1'b0;

    // Read coinciding with arrival (R11); rx_rdy is 1 here
    chk("R11 pending before", int'(rx_rdy), 1);
    send(8'h96);
    for (int i = 0; i < 100 && ss_n; i++) @(negedge clk);
    tick(9 * 3);
    pulse_rd();
    chk("R11 fresh rx_rdy", int'(rx_rdy), 1);
    chk("R11 no overrun on same-cycle read", int'(rx_ovr), 0);
    wait_empty("R11 end");
    chk("R11 fresh data", int'(rx_data), int'(slv_byte(nbytes - 1)));
    pulse_rd();

    // Forced select (R10)
    cmd_force_sel = 1'b1; @(negedge clk); cmd_force_sel = 1'b0;
    chk("R10 forced low", int'(ss_n), 0);
    s0 = nss; n0 = nbytes;
    send(8'h12); send(8'hED);
    wait_empty("R10 forced frames");
    chk("R10 no release between", nss - s0, 0);
    chk("R10 frames sent", nbytes - n0, 2);
    chk("R10 last byte", int'(mos_last), 8'hED);
    chk("R10 still low idle", int'(ss_n), 0);
    cmd_force_sel = 1'b1; cmd_release_sel = 1'b1; @(negedge clk);
    cmd_force_sel = 1'b0; cmd_release_sel = 1'b0;
    chk("R10 release wins", int'(ss_n), 1);
    pulse_rd();
    cmd_clr_status = 1'b1; @(negedge clk); cmd_clr_status = 1'b0;

    // Disabled transmitter (R3)
    tx_en = 1'b0; tick(1);
    chk("R3 disabled tx_rdy", int'(tx_rdy), 0);
    chk("R3 disabled tx_empty", int'(tx_empty), 0);
    n0 = nbytes;
    wr_data = 8'hAA; wr_thr = 1'b1; @(negedge clk); wr_thr = 1'b0;
    tick(60);
    chk("R3 no frame while disabled", nbytes - n0, 0);
    tx_en = 1'b1; tick(1);
    chk("R3 write lost", int'(tx_empty), 1);
    tick(60);
    chk("R3 nothing sent later", nbytes - n0, 0);

    report();
  end
endmodule